// File: doc/BRIEF.md
# Sample-Rate and TDM Frame Timer

This block produces all the timing for a six-channel converter interface that samples every channel at once. It works from one master clock. A master-clock divider produces an internal converter tick. Every eighth converter tick is a modulator sample tick. A period counter marks the end of each output sample period. At that point the block raises a one-cycle sample-valid strobe. If the serial side is idle, it also starts a new time-division-multiplexed frame. A frame is one frame-sync bit followed by six fixed 16-bit channel slots. The block drives the gated serial bit clock of the frame itself.

Three fields from a control register interface set the timing:
- a 3-bit converter-clock divider code;
- a 2-bit serial-clock divider code;
- a 2-bit output-rate code, with a write strobe.

Until the rate is first written, the block runs at a slow default period of 2048 converter ticks. Both divider codes are sampled only when a frame starts, so the timing of a frame already in flight never changes.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is asserted, sclk, fsync, mod_tick and samp_valid are 0 and slot_idx is 0.
- R2: Divider code n in 0..5 makes one converter tick every n+1 master cycles. Codes 6 and 7 give a tick on every master cycle.
- R3: mod_tick is a one-master-cycle pulse once per 8 converter ticks. Every sample period ends on such a tick.
- R4: Until rate_wr has been pulsed, the sample period is 2048 converter ticks, whatever rate_code holds.
- R5: A value written with rate_wr applies from the next period end. Rate codes 0, 1, 2 and 3 give 256, 128, 64 and 32 modulator ticks per sample.
- R6: samp_valid is a one-master-cycle pulse, one master cycle after the last converter tick of each sample period.
- R7: A frame starts at a period end when no frame is active. fsync is then high for exactly one serial bit, which is 2·2^s converter ticks, before slot 0.
- R8: After fsync, slot_idx steps 0,1,2,3,4,5, holding each value for 16 serial bits, and rests at 0 when idle.
- R9: During a frame, sclk is high for 2^s converter ticks and then low for 2^s, where s is the latched serial divider code. sclk is low when idle.
- R10: cdiv_code and sdiv_code are sampled only at a frame start. A change during a frame leaves that frame's timing unchanged.
- R11: A period end that falls while a frame is active starts no frame. The active frame runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cdiv_code | input | 3 | Converter-clock divider code |
| sdiv_code | input | 2 | Serial-clock divider code |
| rate_code | input | 2 | Output rate code |
| rate_wr | input | 1 | One-cycle write strobe for rate_code |
| sclk | output | 1 | Gated serial bit clock |
| fsync | output | 1 | Frame-sync, one serial bit wide |
| slot_idx | output | 3 | Current channel slot |
| mod_tick | output | 1 | Modulator sample tick |
| samp_valid | output | 1 | Output sample strobe |

## Verification
The block is exercised in six stages:
- the default rate, with a non-default rate_code present but not written;
- two rate writes, which separate each decimation ratio from the default;
- divider codes 2 and 7, which show the n+1 division and the fallback to divide-by-one;
- a serial divider change in the middle of a frame, which exposes any early latching;
- a slow serial clock against the shortest period, which forces period ends to land inside an active frame and exposes truncation or restarts;
- a final mixed setting with all codes non-zero.

At every cycle, the outputs are compared with a behavioural model that counts serial bits with plain integers.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;
    localparam int NUM_SLOTS      = 6;
    localparam int SLOT_BITS      = 16;
    localparam int CDIV_W         = 3;
    localparam int CDIV_MAX       = 5;
    localparam int SDIV_W         = 2;
    localparam int RATE_W         = 2;
    localparam int MOD_OSR        = 8;
    localparam int MAX_DECIM      = 256;
    localparam int DEFAULT_PERIOD = 2048;
endpackage

// File: rtl/tdm_clk_prescaler.sv
module tdm_clk_prescaler #(
    parameter int CDIV_W   = 3,
    parameter int CDIV_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CDIV_W-1:0] code_i,
    output logic              ce_o
);
    typedef struct packed {
        logic [CDIV_W-1:0] cnt;
        logic [CDIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign ce_o = (st_q.cnt == st_q.div);

    always_comb begin
        st_d     = st_q;
        st_d.cnt = ce_o ? '0 : st_q.cnt + 1'b1;
        if (load_i) begin
            st_d.div = (code_i <= CDIV_W'(CDIV_MAX)) ? code_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div <= CDIV_W'(CDIV_MAX));
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.div);
endmodule

// File: rtl/tdm_rate_timer.sv
module tdm_rate_timer #(
    parameter int RATE_W         = 2,
    parameter int MOD_OSR        = 8,
    parameter int MAX_DECIM      = 256,
    parameter int DEFAULT_PERIOD = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              rate_wr_i,
    input  logic [RATE_W-1:0] rate_code_i,
    output logic              mod_evt_o,
    output logic              samp_evt_o
);
    localparam int PER_W = $clog2(DEFAULT_PERIOD);
    localparam int OSR_W = $clog2(MOD_OSR);

    typedef struct packed {
        logic [PER_W-1:0]  pos;
        logic [PER_W-1:0]  last;
        logic [RATE_W-1:0] pend;
        logic              written;
    } rate_st_t;

    rate_st_t st_d, st_q;

    function automatic logic [PER_W-1:0] period_last(input logic [RATE_W-1:0] code);
        return PER_W'(MOD_OSR * (MAX_DECIM >> code) - 1);
    endfunction

    assign mod_evt_o  = ce_i && (st_q.pos[OSR_W-1:0] == '1);
    assign samp_evt_o = ce_i && (st_q.pos == st_q.last);

    always_comb begin
        st_d = st_q;
        if (ce_i) begin
            if (samp_evt_o) begin
                st_d.pos  = '0;
                st_d.last = st_q.written ? period_last(st_q.pend)
                                         : PER_W'(DEFAULT_PERIOD - 1);
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        if (rate_wr_i) begin
            st_d.pend    = rate_code_i;
            st_d.written = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.last    <= PER_W'(DEFAULT_PERIOD - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assert_period_on_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_evt_o |-> mod_evt_o);
    assert_default_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.written |-> st_q.last == PER_W'(DEFAULT_PERIOD - 1));
    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= st_q.last);
endmodule

// File: rtl/tdm_sequencer.sv
module tdm_sequencer #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_BITS = 16,
    parameter int SDIV_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce_i,
    input  logic                         start_i,
    input  logic [SDIV_W-1:0]            sdiv_code_i,
    output logic                         sclk_o,
    output logic                         fsync_o,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_o,
    output logic                         busy_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int BPOS_W = $clog2(SLOT_BITS);
    localparam int TICK_W = 1 << SDIV_W;

    typedef struct packed {
        logic              busy;
        logic              in_fs;
        logic [SLOT_W-1:0] slot;
        logic [BPOS_W-1:0] bpos;
        logic [TICK_W-1:0] tk;
        logic [SDIV_W-1:0] sd;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [TICK_W-1:0] half;
    logic [TICK_W:0]   span;
    logic              bit_end;

    assign half    = TICK_W'(1) << st_q.sd;
    assign span    = {1'b0, half} << 1;
    assign bit_end = ({1'b0, st_q.tk} == span - 1'b1);

    assign sclk_o  = st_q.busy && (st_q.tk < half);
    assign fsync_o = st_q.busy && st_q.in_fs;
    assign slot_o  = st_q.slot;
    assign busy_o  = st_q.busy;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.in_fs = 1'b1;
            st_d.slot  = '0;
            st_d.bpos  = '0;
            st_d.tk    = '0;
            st_d.sd    = sdiv_code_i;
        end else if (st_q.busy && ce_i) begin
            if (!bit_end) begin
                st_d.tk = st_q.tk + 1'b1;
            end else begin
                st_d.tk = '0;
                if (st_q.in_fs) begin
                    st_d.in_fs = 1'b0;
                end else if (st_q.bpos == BPOS_W'(SLOT_BITS - 1)) begin
                    st_d.bpos = '0;
                    if (st_q.slot == SLOT_W'(NUM_SLOTS - 1)) begin
                        st_d.busy = 1'b0;
                        st_d.slot = '0;
                    end else begin
                        st_d.slot = st_q.slot + 1'b1;
                    end
                end else begin
                    st_d.bpos = st_q.bpos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !st_q.busy);
    assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.sd));
    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot < SLOT_W'(NUM_SLOTS));
    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !sclk_o);
    assert_fs_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> slot_o == '0);
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_timing_pkg::*;
#(
    parameter int P_NUM_SLOTS      = NUM_SLOTS,
    parameter int P_SLOT_BITS      = SLOT_BITS,
    parameter int P_CDIV_W         = CDIV_W,
    parameter int P_CDIV_MAX       = CDIV_MAX,
    parameter int P_SDIV_W         = SDIV_W,
    parameter int P_RATE_W         = RATE_W,
    parameter int P_MOD_OSR        = MOD_OSR,
    parameter int P_MAX_DECIM      = MAX_DECIM,
    parameter int P_DEFAULT_PERIOD = DEFAULT_PERIOD
) (
    input  logic                           clk_mst,
    input  logic                           rst_n,
    input  logic [P_CDIV_W-1:0]            cdiv_code,
    input  logic [P_SDIV_W-1:0]            sdiv_code,
    input  logic [P_RATE_W-1:0]            rate_code,
    input  logic                           rate_wr,
    output logic                           sclk,
    output logic                           fsync,
    output logic [$clog2(P_NUM_SLOTS)-1:0] slot_idx,
    output logic                           mod_tick,
    output logic                           samp_valid
);
    typedef struct packed {
        logic mod;
        logic sv;
    } strobe_t;

    strobe_t out_d, out_q;
    logic    ce, mod_evt, samp_evt, seq_busy, frame_start;

    assign frame_start = samp_evt && !seq_busy;

    tdm_clk_prescaler #(.CDIV_W(P_CDIV_W), .CDIV_MAX(P_CDIV_MAX)) u_prescaler (
        .clk(clk_mst), .rst_n(rst_n), .load_i(frame_start),
        .code_i(cdiv_code), .ce_o(ce)
    );

    tdm_rate_timer #(
        .RATE_W(P_RATE_W), .MOD_OSR(P_MOD_OSR),
        .MAX_DECIM(P_MAX_DECIM), .DEFAULT_PERIOD(P_DEFAULT_PERIOD)
    ) u_rate (
        .clk(clk_mst), .rst_n(rst_n), .ce_i(ce), .rate_wr_i(rate_wr),
        .rate_code_i(rate_code), .mod_evt_o(mod_evt), .samp_evt_o(samp_evt)
    );

    tdm_sequencer #(
        .NUM_SLOTS(P_NUM_SLOTS), .SLOT_BITS(P_SLOT_BITS), .SDIV_W(P_SDIV_W)
    ) u_seq (
        .clk(clk_mst), .rst_n(rst_n), .ce_i(ce), .start_i(frame_start),
        .sdiv_code_i(sdiv_code), .sclk_o(sclk), .fsync_o(fsync),
        .slot_o(slot_idx), .busy_o(seq_busy)
    );

    always_comb begin
        out_d.mod = mod_evt;
        out_d.sv  = samp_evt;
    end

    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mod_tick   = out_q.mod;
    assign samp_valid = out_q.sv;

    assert_valid_pulse_R6: assert property (@(posedge clk_mst) disable iff (!rst_n)
        samp_valid |=> !samp_valid);
    assert_sv_with_mod_R3: assert property (@(posedge clk_mst) disable iff (!rst_n)
        samp_valid |-> mod_tick);
endmodule

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cdiv_code = 3'd0;
    logic [1:0] sdiv_code = 2'd0;
    logic [1:0] rate_code = 2'd3;
    logic       rate_wr = 1'b0;
    logic       sclk, fsync, mod_tick, samp_valid;
    logic [2:0] slot_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    tdm_frame_timer u_tdm_frame_timer (
        .clk_mst(clk), .rst_n(rst_n), .cdiv_code(cdiv_code), .sdiv_code(sdiv_code),
        .rate_code(rate_code), .rate_wr(rate_wr), .sclk(sclk), .fsync(fsync),
        .slot_idx(slot_idx), .mod_tick(mod_tick), .samp_valid(samp_valid)
    );

    // behavioural reference model, counted in serial bits
    int m_pc = 0, m_div = 0, m_pos = 0, m_last = 2047, m_pend = 0, m_wr = 0;
    int m_busy = 0, m_tk = 0, m_bit = 0, m_sd = 0, m_mod = 0, m_sv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_div = 0; m_pos = 0; m_last = 2047; m_pend = 0; m_wr = 0;
            m_busy = 0; m_tk = 0; m_bit = 0; m_sd = 0; m_mod = 0; m_sv = 0;
        end else begin
            int ce, em, es, st;
            ce = (m_pc == m_div);
            em = ce && (m_pos % 8 == 7);
            es = ce && (m_pos == m_last);
            st = es && !m_busy;
            if (st) begin
                m_busy = 1; m_tk = 0; m_bit = 0; m_sd = sdiv_code;
            end else if (m_busy && ce) begin
                if (m_tk == 2 * (1 << m_sd) - 1) begin
                    m_tk = 0;
                    if (m_bit == 6 * 16) m_busy = 0;
                    else m_bit++;
                end else m_tk++;
            end
            m_pc = ce ? 0 : m_pc + 1;
            if (st) m_div = (cdiv_code <= 5) ? int'(cdiv_code) : 0;
            if (ce) begin
                if (es) begin
                    m_pos = 0;
                    m_last = m_wr ? 8 * (256 >> m_pend) - 1 : 2047;
                end else m_pos++;
            end
            if (rate_wr) begin m_pend = rate_code; m_wr = 1; end
            m_mod = em; m_sv = es;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int e_sclk, e_fs, e_slot;
            e_sclk = m_busy && (m_tk < (1 << m_sd));
            e_fs   = m_busy && (m_bit == 0);
            e_slot = (m_busy && m_bit > 0) ? (m_bit - 1) / 16 : 0;
            check(sclk == e_sclk, "R9 sclk", sclk, e_sclk);
            check(fsync == e_fs, "R7 fsync", fsync, e_fs);
            check(slot_idx == e_slot, "R8 slot_idx", slot_idx, e_slot);
            check(mod_tick == m_mod, "R3 mod_tick", mod_tick, m_mod);
            check(samp_valid == m_sv, "R6 samp_valid", samp_valid, m_sv);
        end
    end

    function automatic logic pick(input int sel);
        case (sel)
            0: return samp_valid;
            1: return mod_tick;
            2: return fsync;
            default: return sclk;
        endcase
    endfunction

    task automatic wait_level(input int sel, input logic v);
        do @(negedge clk); while (pick(sel) !== v);
    endtask

    task automatic gap(input int sel, output int g);
        wait_level(sel, 1'b1);
        g = 0;
        do begin @(negedge clk); g++; end while (pick(sel) !== 1'b1);
    endtask

    task automatic width(input int sel, output int w);
        wait_level(sel, 1'b0);
        wait_level(sel, 1'b1);
        w = 0;
        while (pick(sel) === 1'b1) begin @(negedge clk); w++; end
    endtask

    task automatic write_rate(input logic [1:0] c);
        @(negedge clk); rate_code = c; rate_wr = 1'b1;
        @(negedge clk); rate_wr = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int g, fr, sv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sclk == 0 && fsync == 0 && mod_tick == 0 && samp_valid == 0,
              "R1 strobes in reset", {sclk, fsync, mod_tick, samp_valid}, 0);
        check(slot_idx == 0, "R1 slot in reset", slot_idx, 0);
        rst_n = 1'b1; cmp_on = 1'b1;

        // R4: default period despite rate_code=3 present
        gap(0, g); check(g == 2048, "R4 default period", g, 2048);

        // R5: rate 3 -> 32*8 ticks, rate 1 -> 128*8 ticks
        write_rate(2'd3); wait_level(0, 1'b1);
        gap(0, g); check(g == 256, "R5 rate code 3", g, 256);
        write_rate(2'd1); wait_level(0, 1'b1);
        gap(0, g); check(g == 1024, "R5 rate code 1", g, 1024);
        write_rate(2'd3); wait_level(0, 1'b1);

        // R2: divider codes 2 and 7, latched at a frame start
        cdiv_code = 3'd2; wait_level(2, 1'b0); wait_level(2, 1'b1);
        gap(1, g); check(g == 24, "R2 divider code 2", g, 24);
        gap(0, g); check(g == 768, "R5 period with divider 2", g, 768);
        cdiv_code = 3'd7; wait_level(2, 1'b0); wait_level(2, 1'b1);
        gap(1, g); check(g == 8, "R2 divider code 7", g, 8);

        // R10: serial code change mid-frame does not touch this frame
        wait_level(2, 1'b0);
        sdiv_code = 2'd3;
        width(3, g); check(g == 1, "R10 sclk high held mid-frame", g, 1);
        width(2, g); check(g == 16, "R7 fsync width code 3", g, 16);

        // R11: period ends inside long frames start nothing
        fr = 0; sv = 0;
        for (int i = 0; i < 4000; i++) begin
            logic prev_fs;
            prev_fs = fsync;
            @(negedge clk);
            if (fsync && !prev_fs) fr++;
            if (samp_valid) sv++;
        end
        check(fr > 0 && fr < sv, "R11 frames fewer than periods", fr, sv);

        // mixed codes
        sdiv_code = 2'd1; cdiv_code = 3'd1; write_rate(2'd2);
        repeat (4000) @(negedge clk);
        summary();
    end
endmodule